// File: doc/BRIEF.md
# Multi-Port Memory Array with Per-Port Read Options

This block is a word-addressed storage array with a parameter-set number of write ports and read ports. Every write port has its own clock, active-edge choice, enable, address, data and a per-bit write mask. When two write ports that share an edge hit the same word in the same cycle, the higher-numbered port wins bit by bit.

Each read port is set up on its own by three parameter vectors that hold one bit per read port, with bit r belonging to read port r. The first vector chooses a combinational read or a registered read. The second chooses the active edge of a registered read. The third chooses whether a registered read that meets a same-edge write to the same word returns the new data or the old data. Registered read data clears to zero on a per-port synchronous reset. The array itself has no reset.

The array is built as one bank per write port. Each bank is written only from its own port's clock. A word's value is the XOR of that word across all banks, so no storage element has more than one driver. A transparent read port is assumed to share its clock with the write ports that use the same edge.

Top module: `mport_ram`

## Requirements
- R1: On its active edge, an enabled write port changes only the bits of the addressed word whose wr_mask bit is 1. Bit i of the port-p mask slice wr_mask[p*DATA_W+i] governs data bit i, and bits with a mask of 0 keep their old value.
- R2: A write port with wr_en low changes no word, whatever its address, data and mask are.
- R3: A read port whose RD_SYNC bit is 0 drives rd_data from the array combinationally from rd_addr. Its rd_clk and rd_srst bits are ignored.
- R4: A registered read port samples on the rising edge of its rd_clk bit when its RD_POSEDGE bit is 1, and on the falling edge when that bit is 0.
- R5: A registered read port with RD_PASS 0 returns the word as it was before any write on the same edge to the same address.
- R6: A registered read port with RD_PASS 1 returns the word as left by all writes to that address on the same edge, masked bits merged, from the write ports whose WR_POSEDGE bit equals its RD_POSEDGE bit.
- R7: The RD_PASS bit has no effect on a combinational read port. Such a port shows newly written data right after the write edge.
- R8: When several write ports on one edge write the same word in one cycle, each bit takes the value from the highest-indexed port whose mask bit is 1.
- R9: Write ports writing different words in one cycle all take effect.
- R10: rd_srst high at a registered port's active edge makes its rd_data zero from that edge, and this overrides the read. Other ports and combinational ports are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | RD_PORTS | Clock of each read port, bit r for port r |
| rd_srst | input | RD_PORTS | Synchronous clear of each registered read output |
| rd_addr | input | RD_PORTS*ADDR_W | Read addresses, port r at bits r*ADDR_W upward |
| wr_clk | input | WR_PORTS | Clock of each write port |
| wr_en | input | WR_PORTS | Write enable of each write port |
| wr_addr | input | WR_PORTS*ADDR_W | Write addresses, port p at bits p*ADDR_W upward |
| wr_data | input | WR_PORTS*DATA_W | Write data, port p at bits p*DATA_W upward |
| wr_mask | input | WR_PORTS*DATA_W | Per-bit write mask, same layout as wr_data |
| rd_data | output | RD_PORTS*DATA_W | Read data, port r at bits r*DATA_W upward |

## Verification
The default build has one combinational read port with its pass bit set, one rising-edge old-data port, one rising-edge new-data port and one falling-edge port, and all of them read the same word while writes land on it. A same-cycle read and write to one word separates the old-data port, the new-data port and the combinational port. A write that changes only some bits tells a correct masked merge apart from a whole-word overwrite. Writes from both ports to one word, first with full masks and then with a partial mask on the higher port, show whether priority is resolved per bit. A read sampled half a cycle after an address change shows which edge each port responds to.

// File: rtl/mport_ram_pkg.sv
`timescale 1ns/1ps
package mport_ram_pkg;

    typedef enum logic [1:0] {
        RD_COMB    = 2'd0,
        RD_REG_OLD = 2'd1,
        RD_REG_NEW = 2'd2
    } rd_mode_e;

    function automatic rd_mode_e pick_mode(input bit is_sync, input bit is_pass);
        if (!is_sync) begin
            return RD_COMB;
        end
        return is_pass ? RD_REG_NEW : RD_REG_OLD;
    endfunction

endpackage

// File: rtl/mport_ram_bank.sv
`timescale 1ns/1ps
module mport_ram_bank #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int RD_PORTS = 4,
    parameter int WR_PORTS = 2,
    parameter bit POSEDGE  = 1'b1
) (
    input  logic                                   clk,
    input  logic                                   we,
    input  logic [ADDR_W-1:0]                      waddr,
    input  logic [DATA_W-1:0]                      wdelta,
    input  logic [RD_PORTS-1:0][ADDR_W-1:0]        rd_addr,
    output logic [RD_PORTS-1:0][DATA_W-1:0]        rd_word,
    input  logic [WR_PORTS-1:0][ADDR_W-1:0]        pk_addr,
    output logic [WR_PORTS-1:0][DATA_W-1:0]        pk_word
);

    localparam int DEPTH = 1 << ADDR_W;

    // One bank per write port: only this port's clock ever writes it.
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int r = 0; r < RD_PORTS; r++) begin
            rd_word[r] = mem_q[rd_addr[r]];
        end
        for (int p = 0; p < WR_PORTS; p++) begin
            pk_word[p] = mem_q[pk_addr[p]];
        end
    end

    generate
        if (POSEDGE) begin : g_rise
            always_ff @(posedge clk) begin
                if (we) begin
                    mem_q[waddr] <= mem_q[waddr] ^ wdelta;
                end
            end
        end else begin : g_fall
            always_ff @(negedge clk) begin
                if (we) begin
                    mem_q[waddr] <= mem_q[waddr] ^ wdelta;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mport_ram_rdport.sv
`timescale 1ns/1ps
module mport_ram_rdport
    import mport_ram_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit SYNC    = 1'b1,
    parameter bit POSEDGE = 1'b1,
    parameter bit PASS    = 1'b0
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [DATA_W-1:0] cur_word,
    input  logic [DATA_W-1:0] fwd_word,
    output logic [DATA_W-1:0] rd_data
);

    localparam rd_mode_e MODE = pick_mode(SYNC, PASS);

    logic unused_in;
    assign unused_in = ^{clk, srst, cur_word, fwd_word};

    generate
        if (MODE == RD_COMB) begin : g_comb
            assign rd_data = cur_word;
        end else begin : g_reg
            typedef struct packed {
                logic [DATA_W-1:0] data;
            } rd_state_t;

            rd_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (srst) begin
                    st_d.data = '0;
                end else if (MODE == RD_REG_NEW) begin
                    st_d.data = fwd_word;
                end else begin
                    st_d.data = cur_word;
                end
            end

            assign rd_data = st_q.data;

            if (POSEDGE) begin : g_rise
                always_ff @(posedge clk) begin
                    st_q <= st_d;
                end
                // R10: a clear at this edge leaves zero on the output
                assert_srst_clears_R10: assert property (@(posedge clk)
                    srst |=> (rd_data == '0));
            end else begin : g_fall
                always_ff @(negedge clk) begin
                    st_q <= st_d;
                end
                assert_srst_clears_R10: assert property (@(negedge clk)
                    srst |=> (rd_data == '0));
            end
        end
    endgenerate

endmodule

// File: rtl/mport_ram.sv
`timescale 1ns/1ps
module mport_ram #(
    parameter int                   DATA_W     = 8,
    parameter int                   ADDR_W     = 4,
    parameter int                   RD_PORTS   = 4,
    parameter int                   WR_PORTS   = 2,
    parameter logic [RD_PORTS-1:0]  RD_SYNC    = 4'b1110,
    parameter logic [RD_PORTS-1:0]  RD_POSEDGE = 4'b0111,
    parameter logic [RD_PORTS-1:0]  RD_PASS    = 4'b1101,
    parameter logic [WR_PORTS-1:0]  WR_POSEDGE = 2'b11
) (
    input  logic [RD_PORTS-1:0]          rd_clk,
    input  logic [RD_PORTS-1:0]          rd_srst,
    input  logic [RD_PORTS*ADDR_W-1:0]   rd_addr,
    input  logic [WR_PORTS-1:0]          wr_clk,
    input  logic [WR_PORTS-1:0]          wr_en,
    input  logic [WR_PORTS*ADDR_W-1:0]   wr_addr,
    input  logic [WR_PORTS*DATA_W-1:0]   wr_data,
    input  logic [WR_PORTS*DATA_W-1:0]   wr_mask,
    output logic [RD_PORTS*DATA_W-1:0]   rd_data
);

    localparam bit WR_ONE_EDGE = (WR_POSEDGE == '0) || (WR_POSEDGE == '1);

    logic [WR_PORTS-1:0][ADDR_W-1:0]                wa;
    logic [WR_PORTS-1:0][DATA_W-1:0]                wd, wm;
    logic [RD_PORTS-1:0][ADDR_W-1:0]                ra;
    logic [RD_PORTS-1:0][DATA_W-1:0]                rdo;
    logic [WR_PORTS-1:0][RD_PORTS-1:0][DATA_W-1:0]  bank_rd;
    logic [WR_PORTS-1:0][WR_PORTS-1:0][DATA_W-1:0]  bank_pk;
    logic [RD_PORTS-1:0][DATA_W-1:0]                cur_rd, fwd_rd;
    logic [WR_PORTS-1:0][DATA_W-1:0]                cur_wa, eff_mask, wdelta;
    logic [WR_PORTS-1:0]                            hi_hit, bank_we;

    generate
        for (genvar p = 0; p < WR_PORTS; p++) begin : g_wunpack
            assign wa[p] = wr_addr[p*ADDR_W +: ADDR_W];
            assign wd[p] = wr_data[p*DATA_W +: DATA_W];
            assign wm[p] = wr_mask[p*DATA_W +: DATA_W];
        end
        for (genvar r = 0; r < RD_PORTS; r++) begin : g_runpack
            assign ra[r] = rd_addr[r*ADDR_W +: ADDR_W];
            assign rd_data[r*DATA_W +: DATA_W] = rdo[r];
        end
    endgenerate

    // Word value = XOR of the word across all banks.
    always_comb begin
        for (int r = 0; r < RD_PORTS; r++) begin
            cur_rd[r] = '0;
            for (int b = 0; b < WR_PORTS; b++) begin
                cur_rd[r] = cur_rd[r] ^ bank_rd[b][r];
            end
        end
        for (int p = 0; p < WR_PORTS; p++) begin
            cur_wa[p] = '0;
            for (int b = 0; b < WR_PORTS; b++) begin
                cur_wa[p] = cur_wa[p] ^ bank_pk[b][p];
            end
        end
    end

    // Per-bit priority: a higher-indexed same-edge port masks out lower ones.
    always_comb begin
        for (int p = 0; p < WR_PORTS; p++) begin
            logic [DATA_W-1:0] hi_mask;
            hi_mask   = '0;
            hi_hit[p] = 1'b0;
            for (int q = p + 1; q < WR_PORTS; q++) begin
                if (WR_POSEDGE[q] == WR_POSEDGE[p] && wr_en[q] && wa[q] == wa[p]) begin
                    hi_mask   = hi_mask | wm[q];
                    hi_hit[p] = 1'b1;
                end
            end
            eff_mask[p] = wr_en[p] ? (wm[p] & ~hi_mask) : '0;
            wdelta[p]   = (wd[p] ^ cur_wa[p]) & eff_mask[p];
            bank_we[p]  = |eff_mask[p];
        end
    end

    // Forwarded word for transparent reads: disjoint masks merge by XOR.
    always_comb begin
        for (int r = 0; r < RD_PORTS; r++) begin
            fwd_rd[r] = cur_rd[r];
            for (int p = 0; p < WR_PORTS; p++) begin
                if (WR_POSEDGE[p] == RD_POSEDGE[r] && wa[p] == ra[r]) begin
                    fwd_rd[r] = fwd_rd[r] ^ ((wd[p] ^ cur_rd[r]) & eff_mask[p]);
                end
            end
        end
    end

    generate
        for (genvar p = 0; p < WR_PORTS; p++) begin : g_bank
            mport_ram_bank #(
                .DATA_W  (DATA_W),
                .ADDR_W  (ADDR_W),
                .RD_PORTS(RD_PORTS),
                .WR_PORTS(WR_PORTS),
                .POSEDGE (WR_POSEDGE[p])
            ) bank_i (
                .clk    (wr_clk[p]),
                .we     (bank_we[p]),
                .waddr  (wa[p]),
                .wdelta (wdelta[p]),
                .rd_addr(ra),
                .rd_word(bank_rd[p]),
                .pk_addr(wa),
                .pk_word(bank_pk[p])
            );
        end

        for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
            mport_ram_rdport #(
                .DATA_W (DATA_W),
                .SYNC   (RD_SYNC[r]),
                .POSEDGE(RD_POSEDGE[r]),
                .PASS   (RD_PASS[r])
            ) rdport_i (
                .clk     (rd_clk[r]),
                .srst    (rd_srst[r]),
                .cur_word(cur_rd[r]),
                .fwd_word(fwd_rd[r]),
                .rd_data (rdo[r])
            );

            for (genvar p = 0; p < WR_PORTS; p++) begin : g_chk
                if (RD_SYNC[r] && RD_PASS[r] && RD_POSEDGE[r] == WR_POSEDGE[p]) begin : g_new
                    if (RD_POSEDGE[r]) begin : g_rise
                        assert_pass_new_R6: assert property (@(posedge rd_clk[r]) disable iff (rd_srst[r])
                            (!rd_srst[r] && wr_en[p] && wm[p] == '1 && !hi_hit[p] && wa[p] == ra[r])
                            |=> (rdo[r] == $past(wd[p])));
                    end else begin : g_fall
                        assert_pass_new_R6: assert property (@(negedge rd_clk[r]) disable iff (rd_srst[r])
                            (!rd_srst[r] && wr_en[p] && wm[p] == '1 && !hi_hit[p] && wa[p] == ra[r])
                            |=> (rdo[r] == $past(wd[p])));
                    end
                end
                if (RD_SYNC[r] && !RD_PASS[r] && RD_POSEDGE[r] == WR_POSEDGE[p]) begin : g_old
                    if (RD_POSEDGE[r]) begin : g_rise
                        assert_keep_old_R5: assert property (@(posedge rd_clk[r]) disable iff (rd_srst[r])
                            (!rd_srst[r] && wr_en[p] && wa[p] == ra[r])
                            |=> (rdo[r] == $past(cur_rd[r])));
                    end else begin : g_fall
                        assert_keep_old_R5: assert property (@(negedge rd_clk[r]) disable iff (rd_srst[r])
                            (!rd_srst[r] && wr_en[p] && wa[p] == ra[r])
                            |=> (rdo[r] == $past(cur_rd[r])));
                    end
                end
                if (!RD_SYNC[r] && WR_ONE_EDGE) begin : g_comb
                    if (WR_POSEDGE[p]) begin : g_rise
                        assert_comb_shows_new_R7: assert property (@(posedge wr_clk[p]) disable iff (rd_srst[r])
                            (wr_en[p] && wm[p] == '1 && !hi_hit[p] && wa[p] == ra[r])
                            |=> ((ra[r] != $past(ra[r])) || (rdo[r] == $past(wd[p]))));
                    end else begin : g_fall
                        assert_comb_shows_new_R7: assert property (@(negedge wr_clk[p]) disable iff (rd_srst[r])
                            (wr_en[p] && wm[p] == '1 && !hi_hit[p] && wa[p] == ra[r])
                            |=> ((ra[r] != $past(ra[r])) || (rdo[r] == $past(wd[p]))));
                    end
                end
            end
        end
    endgenerate

endmodule

// File: tb/mport_ram_tb_top.sv
`timescale 1ns/1ps
module mport_ram_tb_top;

    logic        clk = 1'b0;
    logic        rclk0 = 1'b0;
    logic [3:0]  rd_clk;
    logic [3:0]  rd_srst = 4'b0;
    logic [15:0] rd_addr = '0;
    logic [1:0]  wr_clk;
    logic [1:0]  wr_en = 2'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] wr_mask = '0;
    logic [31:0] rd_data;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    assign rd_clk = {clk, clk, clk, rclk0};
    assign wr_clk = {clk, clk};

    mport_ram dut_i (
        .rd_clk (rd_clk),
        .rd_srst(rd_srst),
        .rd_addr(rd_addr),
        .wr_clk (wr_clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .wr_mask(wr_mask),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] rdv(input int r);
        return rd_data[r*8 +: 8];
    endfunction

    task automatic chk(input string req, input int r, input logic [7:0] exp);
        vectors++;
        if (rdv(r) !== exp) begin
            misses++;
            $display("FAIL %s port%0d: got %02h expected %02h", req, r, rdv(r), exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ra(input int r, input logic [3:0] a);
        rd_addr[r*4 +: 4] = a;
    endtask

    task automatic set_ra_all(input logic [3:0] a);
        for (int r = 0; r < 4; r++) set_ra(r, a);
    endtask

    task automatic wr_set(input int p, input logic [3:0] a, input logic [7:0] d, input logic [7:0] m);
        wr_en[p]         = 1'b1;
        wr_addr[p*4 +: 4] = a;
        wr_data[p*8 +: 8] = d;
        wr_mask[p*8 +: 8] = m;
    endtask

    task automatic wr_clear();
        wr_en = 2'b0;
    endtask

    task automatic t_reset();
        rd_srst = 4'b1111;
        cyc(); cyc();
        for (int r = 1; r < 4; r++) chk("R10 reset state", r, 8'h00);
        wr_set(0, 4'd2, 8'h3C, 8'hFF);
        cyc();
        wr_clear();
        set_ra_all(4'd2);
        cyc(); cyc();
        chk("R10 comb port unaffected by clear", 0, 8'h3C);
        for (int r = 1; r < 4; r++) chk("R10 clear overrides read", r, 8'h00);
        rd_srst = 4'b0;
        cyc(); cyc();
        for (int r = 1; r < 4; r++) chk("R4 registered read after clear", r, 8'h3C);
    endtask

    task automatic t_dual_write();
        wr_set(0, 4'd8, 8'h81, 8'hFF);
        wr_set(1, 4'd9, 8'h92, 8'hFF);
        cyc();
        wr_clear();
        set_ra_all(4'd8);
        cyc(); cyc();
        for (int r = 0; r < 4; r++) chk("R9 port0 word", r, 8'h81);
        set_ra_all(4'd9);
        cyc(); cyc();
        for (int r = 0; r < 4; r++) chk("R9 port1 word", r, 8'h92);
    endtask

    task automatic t_edges();
        set_ra(1, 4'd8);
        set_ra(3, 4'd8);
        #0.5;
        chk("R4 falling port before its edge", 3, 8'h92);
        #1;
        chk("R4 falling port after falling edge", 3, 8'h81);
        chk("R4 rising port not yet updated", 1, 8'h92);
        cyc();
        chk("R4 rising port after rising edge", 1, 8'h81);
    endtask

    task automatic t_comb_ignores_clock();
        set_ra(0, 4'd8);
        #0.3;
        chk("R3 comb read with clock held", 0, 8'h81);
        set_ra(0, 4'd9);
        #0.3;
        chk("R3 comb read follows address", 0, 8'h92);
        cyc();
    endtask

    task automatic t_disabled();
        wr_set(0, 4'd8, 8'h00, 8'hFF);
        wr_set(1, 4'd9, 8'h00, 8'hFF);
        wr_en = 2'b00;
        cyc(); cyc();
        set_ra(0, 4'd8);
        #0.3;
        chk("R2 disabled write port0", 0, 8'h81);
        set_ra(0, 4'd9);
        #0.3;
        chk("R2 disabled write port1", 0, 8'h92);
        cyc();
    endtask

    task automatic t_mask();
        set_ra(0, 4'd8);
        wr_set(0, 4'd8, 8'h7E, 8'hF0);
        cyc();
        wr_clear();
        chk("R1 masked write merges bits", 0, 8'h71);
    endtask

    task automatic t_collision();
        wr_set(0, 4'd5, 8'h11, 8'hFF);
        cyc();
        wr_clear();
        set_ra_all(4'd5);
        wr_set(0, 4'd5, 8'h22, 8'hFF);
        cyc();
        wr_clear();
        chk("R5 old data on same-cycle read", 1, 8'h11);
        chk("R6 new data on same-cycle read", 2, 8'h22);
        chk("R7 comb port with pass bit shows new", 0, 8'h22);
        chk("R4 falling port sampled before write", 3, 8'h11);
    endtask

    task automatic t_masked_pass();
        wr_set(1, 4'd6, 8'hF0, 8'hFF);
        cyc();
        wr_clear();
        set_ra_all(4'd6);
        wr_set(1, 4'd6, 8'h0F, 8'h0C);
        cyc();
        wr_clear();
        chk("R6 forwarded masked merge", 2, 8'hFC);
        chk("R5 old data under masked write", 1, 8'hF0);
        cyc();
        chk("R1 masked word after write", 1, 8'hFC);
    endtask

    task automatic t_priority();
        set_ra_all(4'd7);
        wr_set(0, 4'd7, 8'hAA, 8'hFF);
        wr_set(1, 4'd7, 8'h55, 8'hFF);
        cyc();
        chk("R8 higher port wins", 0, 8'h55);
        chk("R8 forwarded winner", 2, 8'h55);
        wr_set(0, 4'd7, 8'hAA, 8'hFF);
        wr_set(1, 4'd7, 8'h55, 8'h0F);
        cyc();
        wr_clear();
        chk("R8 per-bit priority", 0, 8'hA5);
        chk("R8 per-bit forward", 2, 8'hA5);
    endtask

    task automatic t_port_clear();
        rd_srst = 4'b0100;
        cyc(); cyc();
        chk("R10 cleared port", 2, 8'h00);
        chk("R10 other port untouched", 1, 8'hA5);
        chk("R10 falling port untouched", 3, 8'hA5);
        rd_srst = 4'b0;
        cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_dual_write();
        t_edges();
        t_comb_ignores_clock();
        t_disabled();
        t_mask();
        t_collision();
        t_masked_pass();
        t_priority();
        t_port_clear();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule